// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a single-port synchronous SRAM for a processor's secondary cache. Its data path is 18 bits wide, split into two 9-bit byte lanes, and each lane carries its own parity bit. Address, chip enables, strobes, write controls and write data are all sampled on the rising clock edge. Read data comes straight from the array for the address taken at the latest edge, so it is valid within the same clock period. The bus is modelled as a read-data output, a write-data input and a drive-enable output, which together stand for one shared tri-state bus.

There are two ways to start an access. A processor strobe always starts a read. A controller strobe starts either a read or a write, depending on the write controls. After a start, cycles with both strobes idle either step a two-bit wrapping burst counter or hold the current address, and each such cycle may read or write. A strap input selects the burst order. Output enable acts on the drive enable combinationally.

Top module: `fts_sram`

## Requirements
- R1: When `wr_all_n` is low in a write-capable cycle, both lanes (bits 17:0) are written, whatever `wr_byte_n` and `lane_sel_n` are.
- R2: When `wr_all_n` is high and `wr_byte_n` is low, only the selected lanes are written: `lane_sel_n[0]` low writes lane A (bits 8:0) and `lane_sel_n[1]` low writes lane B (bits 17:9).
- R3: A cycle is a read when `wr_all_n` is high and either `wr_byte_n` is high or both `lane_sel_n` bits are high.
- R4: With `en1_n` low, a low `cpu_stb_n` starts a read at `addr` and ignores the write controls. It wins over `ctl_stb_n`. While `en1_n` is high, `cpu_stb_n` has no effect.
- R5: With the block selected (`en1_n` low, `en2` high, `en3_n` low) and `cpu_stb_n` not in effect, a low `ctl_stb_n` starts an access at `addr`. If the write controls are active, that same edge writes `dq_i` at `addr`; otherwise the cycle is a read. A low `ctl_stb_n` while not selected deselects the block.
- R6: With both strobes idle and a burst open, `step_n` low moves to the next burst address and `step_n` high keeps the current one. Either kind of cycle may read or write.
- R7: A burst changes only address bits 1:0 and wraps after four addresses. When `order_xor` is 0 the offset k gives (start+k) mod 4; when it is 1 it gives start XOR k.
- R8: `dq_o` shows the word at the address used by the latest edge, including a word written at that edge, without waiting for another clock.
- R9: `dq_en` is low in any cycle decoded as a write, even if `out_en_n` is low. After a write it stays low through hold reads until a start or an advance cycle.
- R10: `dq_en` is high only in an open read cycle with `out_en_n` low, and it follows `out_en_n` without a clock.
- R11: The first read that starts from the deselected state, including the first one after reset, does not drive the bus.
- R12: Reset leaves the block deselected with `dq_en` low. Idle strobes while deselected keep it deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Word address sampled at start cycles |
| en1_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| en2 | input | 1 | Chip enable, active high |
| en3_n | input | 1 | Chip enable, active low |
| cpu_stb_n | input | 1 | Processor address strobe, active low |
| ctl_stb_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Write both lanes, active low |
| wr_byte_n | input | 1 | Per-lane write enable, active low |
| lane_sel_n | input | 2 | Lane selects, active low, bit 0 lane A, bit 1 lane B |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| order_xor | input | 1 | Burst order strap: 1 XOR order, 0 wrapping increment |
| dq_i | input | 18 | Write data sampled at the edge |
| dq_o | output | 18 | Flow-through read data |
| dq_en | output | 1 | Bus drive enable |

## Verification
The bench checks a processor-strobe start with every write control asserted. A design that honoured those controls would overwrite the word instead of returning it. It steps a burst past its fourth beat in both orders: a counter that carried into bit 2 or mixed up the orders would land on the wrong word. It follows a write with a hold read and checks that the bus stays released, then checks the masked first read after deselection, where a careless design would drive stale data. It also writes single lanes so that a swapped or merged lane decode would show up as damaged neighbour bits.

// File: rtl/fts_pkg.sv
package fts_pkg;
    localparam int LANE_W  = 9;
    localparam int LANES   = 2;
    localparam int DATA_W  = LANE_W * LANES;
    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        CYC_DESEL = 2'd0,
        CYC_START = 2'd1,
        CYC_NEXT  = 2'd2,
        CYC_HOLD  = 2'd3
    } cyc_e;
endpackage

// File: rtl/fts_cycle_decode.sv
module fts_cycle_decode
    import fts_pkg::*;
(
    input  logic             en1_n,
    input  logic             en2,
    input  logic             en3_n,
    input  logic             cpu_stb_n,
    input  logic             ctl_stb_n,
    input  logic             step_n,
    input  logic             wr_all_n,
    input  logic             wr_byte_n,
    input  logic [LANES-1:0] lane_sel_n,
    input  logic             open_q,
    output cyc_e             kind,
    output logic [LANES-1:0] lane_we
);
    logic             sel;
    logic             cpu_act;
    logic [LANES-1:0] lane_req;

    always_comb begin
        sel     = !en1_n && en2 && !en3_n;
        cpu_act = !cpu_stb_n && !en1_n;
        // R1, R2, R3: lane write request from the write controls
        if (!wr_all_n)      lane_req = '1;
        else if (!wr_byte_n) lane_req = ~lane_sel_n;
        else                 lane_req = '0;

        kind    = CYC_DESEL;
        lane_we = '0;
        if (cpu_act) begin
            // R4: processor strobe always reads
            kind = sel ? CYC_START : CYC_DESEL;
        end else if (!ctl_stb_n) begin
            // R5
            kind    = sel ? CYC_START : CYC_DESEL;
            lane_we = sel ? lane_req : '0;
        end else if (open_q) begin
            // R6
            kind    = step_n ? CYC_HOLD : CYC_NEXT;
            lane_we = lane_req;
        end
    end
endmodule

// File: rtl/fts_burst_addr.sv
module fts_burst_addr #(
    parameter int ADDR_W  = 6,
    parameter int BURST_W = 2
) (
    input  logic [ADDR_W-1:0]  base,
    input  logic [BURST_W-1:0] cnt,
    input  logic               order_xor,
    output logic [ADDR_W-1:0]  word_addr
);
    logic [BURST_W-1:0] low;

    // R7: only the low bits move; they wrap inside the burst
    always_comb begin
        if (order_xor) low = base[BURST_W-1:0] ^ cnt;
        else           low = base[BURST_W-1:0] + cnt;
        word_addr = {base[ADDR_W-1:BURST_W], low};
    end
endmodule

// File: rtl/fts_lane_array.sv
module fts_lane_array #(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        // R8: combinational read path
        assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
    end
endmodule

// File: rtl/fts_sram.sv
module fts_sram
    import fts_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              en1_n,
    input  logic              en2,
    input  logic              en3_n,
    input  logic              cpu_stb_n,
    input  logic              ctl_stb_n,
    input  logic              step_n,
    input  logic              wr_all_n,
    input  logic              wr_byte_n,
    input  logic [1:0]        lane_sel_n,
    input  logic              out_en_n,
    input  logic              order_xor,
    input  logic [17:0]       dq_i,
    output logic [17:0]       dq_o,
    output logic              dq_en
);
    typedef struct packed {
        logic               open;
        logic [ADDR_W-1:0]  base;
        logic [BURST_W-1:0] cnt;
        logic               hz;
        logic               first;
    } st_t;

    st_t                st_d, st_q;
    cyc_e               kind;
    logic [LANES-1:0]   lane_we;
    logic               wr_any;
    logic [BURST_W-1:0] w_cnt;
    logic [ADDR_W-1:0]  w_burst, w_addr, r_addr;
    logic               busy;

    fts_cycle_decode u_dec (
        .en1_n      (en1_n),
        .en2        (en2),
        .en3_n      (en3_n),
        .cpu_stb_n  (cpu_stb_n),
        .ctl_stb_n  (ctl_stb_n),
        .step_n     (step_n),
        .wr_all_n   (wr_all_n),
        .wr_byte_n  (wr_byte_n),
        .lane_sel_n (lane_sel_n),
        .open_q     (st_q.open),
        .kind       (kind),
        .lane_we    (lane_we)
    );

    assign wr_any = |lane_we;
    assign w_cnt  = (kind == CYC_NEXT) ? st_q.cnt + 1'b1 : st_q.cnt;

    fts_burst_addr #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_wseq (
        .base      (st_q.base),
        .cnt       (w_cnt),
        .order_xor (order_xor),
        .word_addr (w_burst)
    );

    fts_burst_addr #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_rseq (
        .base      (st_q.base),
        .cnt       (st_q.cnt),
        .order_xor (order_xor),
        .word_addr (r_addr)
    );

    assign w_addr = (kind == CYC_START) ? addr : w_burst;

    always_comb begin
        st_d = st_q;
        unique case (kind)
            CYC_DESEL: begin
                st_d.open  = 1'b0;
                st_d.hz    = 1'b0;
                st_d.first = 1'b0;
            end
            CYC_START: begin
                st_d.open  = 1'b1;
                st_d.base  = addr;
                st_d.cnt   = '0;
                st_d.hz    = wr_any;
                st_d.first = !wr_any && !st_q.open;   // R11
            end
            CYC_NEXT: begin
                st_d.cnt   = st_q.cnt + 1'b1;
                st_d.hz    = wr_any;
                st_d.first = 1'b0;
            end
            default: begin
                st_d.hz    = wr_any || st_q.hz;       // R9
                st_d.first = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    fts_lane_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_mem (
        .clk   (clk),
        .we    (lane_we),
        .waddr (w_addr),
        .wdata (dq_i),
        .raddr (r_addr),
        .rdata (dq_o)
    );

    assign busy  = st_q.open;
    // R10: output enable acts without a clock
    assign dq_en = st_q.open && !st_q.hz && !st_q.first && !out_en_n;
endmodule

// File: rtl/fts_sram_chk.sv
module fts_sram_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en1_n,
    input logic       en2,
    input logic       en3_n,
    input logic       cpu_stb_n,
    input logic       ctl_stb_n,
    input logic       wr_all_n,
    input logic       wr_byte_n,
    input logic [1:0] lane_sel_n,
    input logic       out_en_n,
    input logic       busy,
    input logic       dq_en
);
    logic sel, wreq;
    assign sel  = !en1_n && en2 && !en3_n;
    assign wreq = !wr_all_n || (!wr_byte_n && (lane_sel_n != 2'b11));

    assert_oe_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !dq_en);

    assert_write_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_stb_n && cpu_stb_n && sel && wreq) |=> !dq_en);

    assert_deselect_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_stb_n && en1_n) |=> !dq_en);

    assert_cpu_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_stb_n && sel && busy && dq_en) |=> (out_en_n || dq_en));

    assert_first_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_stb_n && sel && !busy) |=> !dq_en);

    always @(posedge clk) begin
        if (!rst_n) assert_reset_idle_R12: assert (!dq_en);
    end
endmodule

bind fts_sram fts_sram_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en1_n      (en1_n),
    .en2        (en2),
    .en3_n      (en3_n),
    .cpu_stb_n  (cpu_stb_n),
    .ctl_stb_n  (ctl_stb_n),
    .wr_all_n   (wr_all_n),
    .wr_byte_n  (wr_byte_n),
    .lane_sel_n (lane_sel_n),
    .out_en_n   (out_en_n),
    .busy       (busy),
    .dq_en      (dq_en)
);

// File: tb/fts_sram_tb.sv
`timescale 1ns/1ps
module fts_sram_tb;
    typedef struct packed {
        logic        sp_n;
        logic        sc_n;
        logic        st_n;
        logic        ga_n;
        logic        gb_n;
        logic [1:0]  bs_n;
        logic        ce;
        logic [5:0]  a;
        logic [17:0] d;
        logic        oe_n;
        logic        xdrv;
        logic [17:0] xq;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    // fields: sp_n sc_n st_n ga_n gb_n bs_n ce a d oe_n xdrv xq req
    localparam vec_t TBL [NV] = '{
        '{1,0,1,0,1,2'b11,1,6'd4,18'h11111,1,0,18'h0,4'd1},  // R1 R5 ctl write addr4
        '{1,1,0,0,1,2'b11,1,6'd0,18'h22222,1,0,18'h0,4'd6},  // R6 next write addr5
        '{1,1,0,0,1,2'b11,1,6'd0,18'h03333,1,0,18'h0,4'd6},  // R6 addr6
        '{1,1,0,0,1,2'b11,1,6'd0,18'h04444,1,0,18'h0,4'd6},  // R6 addr7
        '{1,1,0,0,1,2'b11,1,6'd0,18'h05555,1,0,18'h0,4'd7},  // R7 wrap to addr4
        '{0,1,1,0,0,2'b00,1,6'd5,18'h3FFFF,0,1,18'h22222,4'd4}, // R4 cpu read ignores writes
        '{1,1,1,1,0,2'b10,1,6'd0,18'h3FFFF,0,0,18'h0,4'd2},  // R2 lane A write addr5
        '{1,1,1,1,1,2'b11,1,6'd0,18'h0,0,0,18'h0,4'd9},      // R9 hold read stays released
        '{1,0,1,1,1,2'b11,1,6'd5,18'h0,0,1,18'h223FF,4'd2},  // R2 R5 ctl read addr5
        '{1,1,1,1,0,2'b01,1,6'd0,18'h00000,0,0,18'h0,4'd2},  // R2 lane B write addr5
        '{1,1,0,1,1,2'b11,1,6'd0,18'h0,0,1,18'h03333,4'd8},  // R8 R9 advance read addr6
        '{1,1,0,1,1,2'b11,1,6'd0,18'h0,1,0,18'h0,4'd10},     // R10 oe high addr7
        '{1,1,0,1,1,2'b11,1,6'd0,18'h0,0,1,18'h05555,4'd7},  // R7 linear wrap to addr4
        '{1,1,1,1,0,2'b11,1,6'd0,18'h3FFFF,0,1,18'h05555,4'd3}, // R3 no lane -> read
        '{1,0,1,1,1,2'b11,0,6'd0,18'h0,0,0,18'h0,4'd5},      // R5 deselect
        '{0,1,1,1,1,2'b11,0,6'd7,18'h0,0,0,18'h0,4'd12},     // R4 R12 cpu strobe ignored
        '{0,1,1,1,1,2'b11,1,6'd6,18'h0,0,0,18'h0,4'd11},     // R11 first read masked
        '{1,1,1,1,1,2'b11,1,6'd0,18'h0,0,1,18'h03333,4'd6},  // R6 hold read addr6
        '{0,0,1,0,1,2'b11,1,6'd6,18'h00001,0,1,18'h03333,4'd4}, // R4 cpu beats ctl
        '{1,1,1,1,1,2'b11,1,6'd0,18'h0,0,1,18'h03333,4'd4},  // R4 nothing written
        '{1,0,1,0,1,2'b11,1,6'd9,18'h0F0F0,0,0,18'h0,4'd9},  // R9 write with oe low
        '{1,0,1,1,1,2'b11,1,6'd9,18'h0,0,1,18'h0F0F0,4'd5}   // R5 ctl read back
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr = '0;
    logic        en1_n = 1'b1, en2 = 1'b1, en3_n = 1'b0;
    logic        cpu_stb_n = 1'b1, ctl_stb_n = 1'b1, step_n = 1'b1;
    logic        wr_all_n = 1'b1, wr_byte_n = 1'b1;
    logic [1:0]  lane_sel_n = 2'b11;
    logic        out_en_n = 1'b1, order_xor = 1'b0;
    logic [17:0] dq_i = '0;
    logic [17:0] dq_o;
    logic        dq_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    fts_sram u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .en1_n(en1_n), .en2(en2),
        .en3_n(en3_n), .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n),
        .step_n(step_n), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n),
        .lane_sel_n(lane_sel_n), .out_en_n(out_en_n), .order_xor(order_xor),
        .dq_i(dq_i), .dq_o(dq_o), .dq_en(dq_en)
    );

    function automatic vec_t mk(logic sp, logic sc, logic st, logic ga,
                                logic [5:0] a, logic [17:0] d, logic xd,
                                logic [17:0] q, logic [3:0] r);
        vec_t v;
        v = '{sp, sc, st, ga, 1'b1, 2'b11, 1'b1, a, d, 1'b0, xd, q, r};
        return v;
    endfunction

    task automatic check(input bit ok, input logic [3:0] r, input string what,
                         input logic [17:0] act, input logic [17:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", r, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        cpu_stb_n  = v.sp_n;
        ctl_stb_n  = v.sc_n;
        step_n     = v.st_n;
        wr_all_n   = v.ga_n;
        wr_byte_n  = v.gb_n;
        lane_sel_n = v.bs_n;
        en1_n      = !v.ce;
        addr       = v.a;
        dq_i       = v.d;
        out_en_n   = v.oe_n;
        @(posedge clk);
        #1;
        check(dq_en == v.xdrv, v.req, "drive", {17'd0, dq_en}, {17'd0, v.xdrv});
        if (v.xdrv) check(dq_o == v.xq, v.req, "data", dq_o, v.xq);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(dq_en == 1'b0, 4'd12, "reset drive", {17'd0, dq_en}, 18'd0); // R12
        @(negedge clk);
        rst_n = 1'b1;
        // R12: idle strobes after reset keep the bus released
        apply('{1,1,0,1,1,2'b11,1,6'd0,18'h0,0,0,18'h0,4'd12});
        for (int i = 0; i < NV; i++) apply(TBL[i]);

        // R7: XOR order from start offset 1 -> 0x11, 0x10, 0x13, 0x12
        @(negedge clk);
        order_xor = 1'b1;
        apply(mk(1, 0, 1, 0, 6'h11, 18'h00100, 0, 18'h0, 4'd7));
        apply(mk(1, 1, 0, 0, 6'h00, 18'h00101, 0, 18'h0, 4'd7));
        apply(mk(1, 1, 0, 0, 6'h00, 18'h00102, 0, 18'h0, 4'd7));
        apply(mk(1, 1, 0, 0, 6'h00, 18'h00103, 0, 18'h0, 4'd7));
        apply(mk(1, 0, 1, 1, 6'h10, 18'h0, 1, 18'h00101, 4'd7));
        apply(mk(1, 0, 1, 1, 6'h11, 18'h0, 1, 18'h00100, 4'd7));
        apply(mk(1, 0, 1, 1, 6'h13, 18'h0, 1, 18'h00102, 4'd7));
        apply(mk(1, 0, 1, 1, 6'h12, 18'h0, 1, 18'h00103, 4'd7));
        // R7: advance from 0x12 in XOR order lands on 0x13
        apply(mk(1, 1, 0, 1, 6'h00, 18'h0, 1, 18'h00102, 4'd7));
        // R8: write then read back same word with no extra wait
        apply(mk(1, 0, 1, 0, 6'h20, 18'h2AA55, 0, 18'h0, 4'd8));
        apply(mk(1, 1, 1, 1, 6'h00, 18'h0, 0, 18'h0, 4'd9));
        apply(mk(1, 0, 1, 1, 6'h20, 18'h0, 1, 18'h2AA55, 4'd8));
        // R10: oe released without a clock edge
        #1 out_en_n = 1'b1;
        #0.5;
        check(dq_en == 1'b0, 4'd10, "async oe", {17'd0, dq_en}, 18'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R12 watchdog: actual %h expected %h", 18'd0, 18'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end
endmodule